// File: doc/BRIEF.md
# Event Input Timestamp Recorder

This block watches an active-high external event input, for example a chassis-open switch, and records the current time and date whenever the input shows a new event. The first event after a first-slot clear is locked into a dedicated slot. Every later event goes into a small rolling history that keeps only the newest entries. The host selects a history entry with an index and reads it back.

An active-low detect output goes low on any recorded event and stays low until the host clears the event flag. Two control bits decide whether events are seen at all. One enables detection. The other keeps detection active while the system runs from backup power. The event pin is asynchronous and passes through a two-flop synchronizer. Only a rising edge of the synchronized level counts, and no further debounce filtering is done.

Top module: `evt_stamp_rec`

## Requirements
- R1: After reset, `evt_n_o` is 1, `first_valid_o` is 0, `evt_cnt_o` is 0, and `first_ts_o` and `hist_ts_o` are all zeros.
- R2: An event is recorded on the third rising clock edge after `evt_pin_i` rises, and not before. A level held high for many cycles records exactly one event.
- R3: When `det_en_i` is 0, the synchronized input is forced low, and a pulse on `evt_pin_i` records nothing and leaves `evt_n_o` high.
- R4: When `on_bat_i` is 1, events are ignored unless `bat_en_i` is 1. With both at 1, events are recorded normally.
- R5: The first event captures `time_i` into `first_ts_o` and sets `first_valid_o`. The value in place on the detection cycle is the one captured. The slot then holds its value across all later events until a first-slot clear. The timestamp layout, from MSB to LSB, is year[6:0], month[3:0], date[4:0], hour[4:0], minute[5:0], second[5:0].
- R6: Each event after the first writes `time_i` into the history and increments `evt_cnt_o`, which saturates at 3.
- R7: `rd_idx_i` = 0 returns the newest history entry, and 1 and 2 return successively older ones. A fourth later event displaces the oldest entry.
- R8: When `rd_idx_i` is greater than or equal to `evt_cnt_o`, `hist_ts_o` is all zeros.
- R9: `evt_n_o` goes low on a recorded event and stays low until a cycle with `clr_flag_i` = 1. If a clear and an event fall on the same cycle, the event wins and `evt_n_o` stays low.
- R10: A cycle with `clr_first_i` = 1 clears `first_valid_o`, `first_ts_o`, the history and the count, and takes priority over an event in the same cycle. The next event then fills the first slot again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_pin_i | input | 1 | Asynchronous event input, active high |
| time_i | input | 33 | Live packed time/date |
| det_en_i | input | 1 | Event detection enable |
| bat_en_i | input | 1 | Keep detection active on backup power |
| on_bat_i | input | 1 | System is running on backup power |
| clr_flag_i | input | 1 | Clear the event flag (one cycle) |
| clr_first_i | input | 1 | Clear first slot, history and count (one cycle) |
| rd_idx_i | input | 2 | History read index, 0 = newest |
| first_valid_o | output | 1 | First slot holds an event |
| first_ts_o | output | 33 | First-event timestamp |
| hist_ts_o | output | 33 | History entry selected by rd_idx_i |
| evt_cnt_o | output | 2 | History entries held, saturating at 3 |
| evt_n_o | output | 1 | Active-low sticky event detect |

## Verification
Short pulses with a distinct time value each show that the first slot and the history are filled in the right order. Reading by index after each pulse separates newest-first ordering, saturation and zero-fill beyond the count. A level held high while the time changes every cycle shows that a held input gives one event and that capture happens on the detection cycle. Pulses with detection disabled, or on backup power with the battery-enable bit both clear and set, show the gating. A flag clear that lands on the detection cycle shows that set has priority over clear.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DATE_W = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 7;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DATE_W-1:0] date;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  minute;
    logic [SEC_W-1:0]  second;
  } stamp_t;

  localparam int STAMP_W = $bits(stamp_t);
endpackage

// File: rtl/evt_in_sync.sv
module evt_in_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic gate_i,
  output logic rise_o
);
  logic [SYNC_N-1:0] sync_q;
  logic lvl, lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_N-2:0], pin_i};
  end

  // gating before the edge detector: a disabled input looks low
  assign lvl = sync_q[SYNC_N-1] & gate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl;
  end

  assign rise_o = lvl & ~lvl_q;
endmodule

// File: rtl/evt_flag.sv
module evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set wins over clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/evt_hist.sv
module evt_hist #(
  parameter int DEPTH   = 3,
  parameter int STAMP_W = 33,
  parameter int IDX_W   = 2,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [STAMP_W-1:0] wdata_i,
  input  logic               clr_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [STAMP_W-1:0] rdata_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [STAMP_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wp_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [PTR_W-1:0]   rd_slot;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem[i] <= '0;
      else if (clr_i)                        mem[i] <= '0;
      else if (wr_i && wp_q == PTR_W'(i))    mem[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (wr_i) begin
      wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end
  end

  // newest entry sits just behind the write pointer
  always_comb begin
    rd_slot = '0;
    rdata_o = '0;
    if (int'(idx_i) < int'(cnt_q)) begin
      rd_slot = PTR_W'((int'(wp_q) + DEPTH - 1 - int'(idx_i)) % DEPTH);
      rdata_o = mem[rd_slot];
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_stamp_rec.sv
module evt_stamp_rec #(
  parameter int HIST_D = 3,
  parameter int IDX_W  = 2,
  parameter int SYNC_N = 2,
  parameter int TS_W   = evt_stamp_pkg::STAMP_W,
  parameter int CNT_W  = $clog2(HIST_D + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_pin_i,
  input  logic [TS_W-1:0]  time_i,
  input  logic             det_en_i,
  input  logic             bat_en_i,
  input  logic             on_bat_i,
  input  logic             clr_flag_i,
  input  logic             clr_first_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             first_valid_o,
  output logic [TS_W-1:0]  first_ts_o,
  output logic [TS_W-1:0]  hist_ts_o,
  output logic [CNT_W-1:0] evt_cnt_o,
  output logic             evt_n_o
);
  logic gate, rise, flag, hist_wr;

  assign gate = det_en_i & (~on_bat_i | bat_en_i);

  evt_in_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (evt_pin_i),
    .gate_i (gate),
    .rise_o (rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_valid_o <= 1'b0;
      first_ts_o    <= '0;
    end else if (clr_first_i) begin
      first_valid_o <= 1'b0;
      first_ts_o    <= '0;
    end else if (rise && !first_valid_o) begin
      first_valid_o <= 1'b1;
      first_ts_o    <= time_i;
    end
  end

  assign hist_wr = rise & first_valid_o & ~clr_first_i;

  evt_hist #(
    .DEPTH   (HIST_D),
    .STAMP_W (TS_W),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W)
  ) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (hist_wr),
    .wdata_i (time_i),
    .clr_i   (clr_first_i),
    .idx_i   (rd_idx_i),
    .cnt_o   (evt_cnt_o),
    .rdata_o (hist_ts_o)
  );

  evt_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (rise),
    .clr_i  (clr_flag_i),
    .flag_o (flag)
  );

  assign evt_n_o = ~flag;
endmodule

// File: rtl/evt_stamp_rec_chk.sv
module evt_stamp_rec_chk #(
  parameter int HIST_D = 3,
  parameter int IDX_W  = 2,
  parameter int TS_W   = 33,
  parameter int CNT_W  = $clog2(HIST_D + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_flag_i,
  input logic             clr_first_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic             first_valid_o,
  input logic [TS_W-1:0]  first_ts_o,
  input logic [TS_W-1:0]  hist_ts_o,
  input logic [CNT_W-1:0] evt_cnt_o,
  input logic             evt_n_o
);
  a_r6_cnt_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(evt_cnt_o) <= HIST_D);

  a_r6_cnt_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_first_i |=> evt_cnt_o >= $past(evt_cnt_o));

  a_r10_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_first_i |=> (!first_valid_o && evt_cnt_o == '0));

  a_r9_sticky_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_n_o && !clr_flag_i) |=> !evt_n_o);

  a_r5_first_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_valid_o && !clr_first_i) |=> (first_valid_o && $stable(first_ts_o)));

  a_r8_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_idx_i) >= int'(evt_cnt_o)) |-> hist_ts_o == '0);
endmodule

bind evt_stamp_rec evt_stamp_rec_chk #(
  .HIST_D (HIST_D),
  .IDX_W  (IDX_W),
  .TS_W   (TS_W),
  .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/tb_evt_stamp_rec.sv
module tb_evt_stamp_rec;
  localparam int TS_W = evt_stamp_pkg::STAMP_W;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            evt_pin = 1'b0;
  logic [TS_W-1:0] time_v = '0;
  logic            det_en = 1'b1, bat_en = 1'b0, on_bat = 1'b0;
  logic            clr_flag = 1'b0, clr_first = 1'b0;
  logic [1:0]      rd_idx = '0;
  logic            first_valid, evt_n;
  logic [TS_W-1:0] first_ts, hist_ts;
  logic [1:0]      evt_cnt;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_stamp_rec dut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_pin_i(evt_pin), .time_i(time_v),
    .det_en_i(det_en), .bat_en_i(bat_en), .on_bat_i(on_bat),
    .clr_flag_i(clr_flag), .clr_first_i(clr_first), .rd_idx_i(rd_idx),
    .first_valid_o(first_valid), .first_ts_o(first_ts), .hist_ts_o(hist_ts),
    .evt_cnt_o(evt_cnt), .evt_n_o(evt_n)
  );

  function automatic logic [TS_W-1:0] mk(int y, int mo, int d, int h, int mi, int s);
    evt_stamp_pkg::stamp_t t;
    t.year = 7'(y); t.month = 4'(mo); t.date = 5'(d);
    t.hour = 5'(h); t.minute = 6'(mi); t.second = 6'(s);
    return t;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] idx, output logic [TS_W-1:0] v);
    rd_idx = idx;
    #1 v = hist_ts;
  endtask

  task automatic do_event(input logic [TS_W-1:0] ts);
    @(negedge clk); time_v = ts; evt_pin = 1'b1;
    repeat (3) @(negedge clk);
    evt_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_clr_flag();
    @(negedge clk); clr_flag = 1'b1;
    @(negedge clk); clr_flag = 1'b0;
  endtask

  logic [TS_W-1:0] t1, t2, t3, t4, t5, t6, t7, t8, t9, t10, v;

  task automatic t_reset();
    chk("R1", "evt_n", 64'(evt_n), 64'd1);
    chk("R1", "first_valid", 64'(first_valid), 64'd0);
    chk("R1", "cnt", 64'(evt_cnt), 64'd0);
    chk("R1", "first_ts", 64'(first_ts), 64'd0);
    rd(2'd0, v); chk("R1", "hist idx0", 64'(v), 64'd0);
  endtask

  task automatic t_first_latency();
    @(negedge clk); time_v = t1; evt_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", "not yet after two edges", 64'(first_valid), 64'd0);
    @(negedge clk);
    chk("R2", "recorded on third edge", 64'(first_valid), 64'd1);
    evt_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5", "first_ts", 64'(first_ts), 64'(t1));
    chk("R9", "evt_n low", 64'(evt_n), 64'd0);
    chk("R6", "cnt after first", 64'(evt_cnt), 64'd0);
  endtask

  task automatic t_flag_clear();
    pulse_clr_flag();
    chk("R9", "evt_n after clear", 64'(evt_n), 64'd1);
  endtask

  task automatic t_hist_fill();
    do_event(t2);
    chk("R6", "cnt=1", 64'(evt_cnt), 64'd1);
    chk("R9", "evt_n low again", 64'(evt_n), 64'd0);
    rd(2'd0, v); chk("R7", "idx0=t2", 64'(v), 64'(t2));
    rd(2'd1, v); chk("R8", "idx1 beyond count", 64'(v), 64'd0);
    do_event(t3);
    do_event(t4);
    chk("R6", "cnt=3", 64'(evt_cnt), 64'd3);
    rd(2'd0, v); chk("R7", "idx0=t4", 64'(v), 64'(t4));
    rd(2'd1, v); chk("R7", "idx1=t3", 64'(v), 64'(t3));
    rd(2'd2, v); chk("R7", "idx2=t2", 64'(v), 64'(t2));
    rd(2'd3, v); chk("R8", "idx3 zero", 64'(v), 64'd0);
    do_event(t5);
    chk("R6", "cnt saturates", 64'(evt_cnt), 64'd3);
    rd(2'd0, v); chk("R7", "idx0=t5", 64'(v), 64'(t5));
    rd(2'd2, v); chk("R7", "oldest displaced", 64'(v), 64'(t3));
    chk("R5", "first held", 64'(first_ts), 64'(t1));
  endtask

  task automatic t_held_level();
    @(negedge clk); time_v = t6; evt_pin = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      time_v = t7 + TS_W'(i);
      @(negedge clk);
    end
    rd(2'd0, v); chk("R2", "held: idx0 captured at detect", 64'(v), 64'(t6));
    rd(2'd1, v); chk("R2", "held: one event only", 64'(v), 64'(t5));
    evt_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_set_wins();
    pulse_clr_flag();
    @(negedge clk); time_v = t7; evt_pin = 1'b1;
    repeat (2) @(negedge clk);
    clr_flag = 1'b1;
    @(negedge clk); clr_flag = 1'b0;
    chk("R9", "set wins over clear", 64'(evt_n), 64'd0);
    evt_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_disable();
    pulse_clr_flag();
    det_en = 1'b0;
    do_event(t8);
    chk("R3", "evt_n stays high", 64'(evt_n), 64'd1);
    rd(2'd0, v); chk("R3", "history untouched", 64'(v), 64'(t7));
    det_en = 1'b1;
  endtask

  task automatic t_battery();
    on_bat = 1'b1; bat_en = 1'b0;
    do_event(t8);
    chk("R4", "ignored on battery", 64'(evt_n), 64'd1);
    rd(2'd0, v); chk("R4", "history untouched", 64'(v), 64'(t7));
    bat_en = 1'b1;
    do_event(t8);
    chk("R4", "recorded with bat_en", 64'(evt_n), 64'd0);
    rd(2'd0, v); chk("R4", "idx0=t8", 64'(v), 64'(t8));
    on_bat = 1'b0; bat_en = 1'b0;
  endtask

  task automatic t_clear_first();
    @(negedge clk); clr_first = 1'b1;
    @(negedge clk); clr_first = 1'b0;
    chk("R10", "first_valid cleared", 64'(first_valid), 64'd0);
    chk("R10", "first_ts cleared", 64'(first_ts), 64'd0);
    chk("R10", "cnt cleared", 64'(evt_cnt), 64'd0);
    rd(2'd0, v); chk("R10", "history reads zero", 64'(v), 64'd0);
    do_event(t9);
    chk("R10", "refill first", 64'(first_ts), 64'(t9));
    chk("R10", "cnt still 0", 64'(evt_cnt), 64'd0);
    do_event(t10);
    chk("R10", "cnt 1 after next", 64'(evt_cnt), 64'd1);
    rd(2'd0, v); chk("R10", "idx0=t10", 64'(v), 64'(t10));
  endtask

  initial begin
    t1 = mk(24, 1, 15, 8, 30, 5);   t2 = mk(24, 2, 3, 12, 1, 59);
    t3 = mk(25, 3, 31, 23, 59, 58); t4 = mk(25, 4, 1, 0, 0, 1);
    t5 = mk(26, 12, 25, 6, 45, 17); t6 = mk(27, 7, 7, 7, 7, 7);
    t7 = mk(28, 8, 9, 10, 11, 12);  t8 = mk(29, 9, 10, 11, 12, 13);
    t9 = mk(30, 10, 20, 20, 20, 20); t10 = mk(99, 11, 30, 19, 58, 57);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_latency();
    t_flag_clear();
    t_hist_fill();
    t_held_level();
    t_set_wins();
    t_disable();
    t_battery();
    t_clear_first();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule